// File: doc/BRIEF.md
# Degraded-Mode Recovery Controller

This controller sits next to a commit-stage checker in an out-of-order core and decides how the pipeline recovers after the checker rejects an instruction. When a rejection arrives during normal operation, it issues a one-cycle global flush. On the same cycle it issues a fetch redirect to the rejected instruction's PC. It then places the core in a degraded mode, where a parameterised mask of performance features (prediction, forwarding and similar) is switched off.

While degraded, the controller allows exactly one instruction to be fetched. It then holds fetch off until that instruction comes back to the checker. A pass returns the core to normal operation, with fetch re-enabled and features restored. A second rejection moves the controller into a terminal error state, which raises an exception and keeps fetch off until reset. A built-in stall watchdog covers deadlock. If the core is busy and nothing reaches the checker for a set number of consecutive cycles during normal operation, the watchdog starts the same recovery at the PC of the oldest uncommitted instruction.

Top module: `degraded_recovery_ctrl`

## Requirements
- R1: After reset the outputs are fetch_en=1, flush=0, redirect_valid=0, degraded=0, exception=0 and feat_off=0.
- R2: In normal mode, a cycle with chk_valid=1 and chk_ok=0 causes the following changes on the next clock edge. flush and redirect_valid go high for exactly one cycle. redirect_pc takes that cycle's chk_pc. degraded goes high.
- R3: In degraded mode, fetch_en is high until the first cycle in which fetch_fire is high. From the edge that ends that cycle, fetch_en stays low until degraded mode is left.
- R4: feat_off equals the FEAT_MASK parameter (default 4'b1011) while degraded=1, and is all zeros otherwise.
- R5: In degraded mode, once the single instruction has been fetched, a cycle with chk_valid=1 and chk_ok=1 returns the controller to normal mode on the next edge. At that point degraded=0, fetch_en=1 and feat_off=0.
- R6: In degraded mode, once the single instruction has been fetched, a cycle with chk_valid=1 and chk_ok=0 enters the error state on the next edge. In the error state exception=1, fetch_en=0 and degraded=0.
- R7: The error state ignores all inputs and emits no flush or redirect. It is left only by asserting rst_n low.
- R8: In degraded mode, checker results that arrive before the single instruction has been fetched are ignored.
- R9: In normal mode, when core_busy=1 and chk_valid=0 for WDOG_CYCLES consecutive cycles (default 16), recovery starts exactly as in R2, with redirect_pc set to oldest_pc. Any cycle with chk_valid=1 or core_busy=0 restarts the count.
- R10: Passing checker results in normal mode leave every output unchanged from its normal-mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Checker has a verdict this cycle |
| chk_ok | input | 1 | Verdict is a pass (meaningful with chk_valid) |
| chk_pc | input | PC_W | PC of the instruction being judged |
| core_busy | input | 1 | Instructions are in flight in the core |
| oldest_pc | input | PC_W | PC of the oldest uncommitted instruction |
| fetch_fire | input | 1 | Fetch stage accepted an instruction this cycle |
| flush | output | 1 | One-cycle global pipeline flush |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | PC_W | PC to refetch from |
| fetch_en | output | 1 | Fetch permitted |
| degraded | output | 1 | Degraded mode active |
| feat_off | output | N_FEAT | Per-feature disable controls |
| exception | output | 1 | Terminal error raised |

## Verification
On every cycle the assertions check the following. Flush lasts one cycle. Entry into degraded mode always comes with a flush and a redirect. The redirect carries the rejected PC. Only one fetch is granted per degraded episode. A pass after the refetch restores fetch. The error state is sticky and never fetches. The watchdog count stays bounded. The directed scenarios are needed for the ordering-dependent behaviour: exact watchdog timing at the limit and one cycle short of it, checker verdicts ignored before the refetch, the feature mask value, and leaving the error state only through reset.

// File: rtl/rcv_pkg.sv
`timescale 1ns/1ps
package rcv_pkg;
   typedef enum logic [1:0] {
      RC_NORMAL   = 2'd0,
      RC_DEGRADED = 2'd1,
      RC_ERROR    = 2'd2
   } rc_state_t;
endpackage

// File: rtl/rcv_watchdog.sv
`timescale 1ns/1ps
module rcv_watchdog #(
   parameter int WDOG_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,      // controller in normal mode
   input  logic busy,
   input  logic progress,   // checker saw an instruction
   output logic timeout
);
   localparam int CNT_W = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WDOG_CYCLES - 1);

   if (WDOG_CYCLES < 2) begin : g_bad_limit
      $error("rcv_watchdog: WDOG_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             stall;

   assign stall   = armed && busy && !progress;
   assign timeout = stall && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!stall || timeout) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R9: the count never runs past the limit
   assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   // R9: a non-stall cycle restarts counting
   assert_count_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> cnt_q == '0);
endmodule

// File: rtl/rcv_refetch_gate.sv
`timescale 1ns/1ps
module rcv_refetch_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active,      // degraded mode
   input  logic fetch_fire,
   output logic grant,       // fetch allowed during degraded mode
   output logic taken        // the single instruction has been fetched
);
   logic taken_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
      end else if (!active) begin
         taken_q <= 1'b0;
      end else if (fetch_fire) begin
         taken_q <= 1'b1;
      end
   end

   assign taken = taken_q;
   assign grant = active && !taken_q;

   // R3: once the one fetch is accepted, no further grant in this episode
   assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && grant && fetch_fire) |=> !grant);
endmodule

// File: rtl/rcv_feature_mask.sv
`timescale 1ns/1ps
module rcv_feature_mask #(
   parameter int                N_FEAT    = 4,
   parameter logic [N_FEAT-1:0] FEAT_MASK = '1
) (
   input  logic              degraded,
   output logic [N_FEAT-1:0] feat_off
);
   if (N_FEAT < 1) begin : g_bad_feat
      $error("rcv_feature_mask: N_FEAT must be at least 1");
   end

   for (genvar i = 0; i < N_FEAT; i++) begin : g_bit
      if (FEAT_MASK[i]) begin : g_ctl
         assign feat_off[i] = degraded;
      end else begin : g_keep
         assign feat_off[i] = 1'b0;
      end
   end
endmodule

// File: rtl/degraded_recovery_ctrl.sv
`timescale 1ns/1ps
module degraded_recovery_ctrl #(
   parameter int                PC_W        = 32,
   parameter int                WDOG_CYCLES = 16,
   parameter bit                WDOG_EN     = 1'b1,
   parameter int                N_FEAT      = 4,
   parameter logic [N_FEAT-1:0] FEAT_MASK   = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_valid,
   input  logic              chk_ok,
   input  logic [PC_W-1:0]   chk_pc,
   input  logic              core_busy,
   input  logic [PC_W-1:0]   oldest_pc,
   input  logic              fetch_fire,
   output logic              flush,
   output logic              redirect_valid,
   output logic [PC_W-1:0]   redirect_pc,
   output logic              fetch_en,
   output logic              degraded,
   output logic [N_FEAT-1:0] feat_off,
   output logic              exception
);
   import rcv_pkg::*;

   if (PC_W < 2) begin : g_bad_pc
      $error("degraded_recovery_ctrl: PC_W must be at least 2");
   end

   rc_state_t       state_q, state_d;
   logic            flush_q, redir_q;
   logic [PC_W-1:0] rpc_q;
   logic            fail_now, timeout, enter, grant, taken;

   // ---- stall watchdog (optional) ----
   if (WDOG_EN) begin : g_wdog
      rcv_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
         .clk     (clk),
         .rst_n   (rst_n),
         .armed   (state_q == RC_NORMAL),
         .busy    (core_busy),
         .progress(chk_valid),
         .timeout (timeout)
      );
   end else begin : g_no_wdog
      assign timeout = 1'b0;
   end

   // ---- single-fetch gate for degraded mode ----
   rcv_refetch_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (state_q == RC_DEGRADED),
      .fetch_fire(fetch_fire),
      .grant     (grant),
      .taken     (taken)
   );

   // ---- feature disables ----
   rcv_feature_mask #(.N_FEAT(N_FEAT), .FEAT_MASK(FEAT_MASK)) u_mask (
      .degraded(degraded),
      .feat_off(feat_off)
   );

   assign fail_now = chk_valid && !chk_ok;
   assign enter    = (state_q == RC_NORMAL) && (fail_now || timeout);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RC_NORMAL:   if (enter) state_d = RC_DEGRADED;
         RC_DEGRADED: if (taken && chk_valid) state_d = chk_ok ? RC_NORMAL : RC_ERROR;
         RC_ERROR:    state_d = RC_ERROR;
         default:     state_d = RC_ERROR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RC_NORMAL;
         flush_q <= 1'b0;
         redir_q <= 1'b0;
         rpc_q   <= '0;
      end else begin
         state_q <= state_d;
         flush_q <= enter;
         redir_q <= enter;
         if (enter) rpc_q <= fail_now ? chk_pc : oldest_pc;
      end
   end

   assign flush          = flush_q;
   assign redirect_valid = redir_q;
   assign redirect_pc    = rpc_q;
   assign degraded       = (state_q == RC_DEGRADED);
   assign exception      = (state_q == RC_ERROR);
   assign fetch_en       = (state_q == RC_NORMAL) || grant;

   // R2: flush is a single-cycle pulse
   assert_flush_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);
   // R2: every entry to degraded mode comes with flush and redirect
   assert_entry_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(degraded) |-> (flush && redirect_valid));
   // R2: redirect carries the rejected PC
   assert_redirect_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!degraded && !exception && chk_valid && !chk_ok) |=> (redirect_pc == $past(chk_pc)));
   // R5: a pass after the refetch restores normal fetch
   assert_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (degraded && !fetch_en && chk_valid && chk_ok) |=> (fetch_en && !degraded));
   // R6: error state never fetches
   assert_error_nofetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exception |-> !fetch_en);
   // R7: error state is sticky and silent
   assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exception |=> (exception && !flush && !redirect_valid));
endmodule

// File: tb/degraded_recovery_ctrl_test.sv
`timescale 1ns/1ps
module degraded_recovery_ctrl_test;
   localparam int PC_W = 32;
   localparam int WD   = 16;
   localparam logic [3:0] MASK = 4'b1011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chk_valid = 1'b0, chk_ok = 1'b0, core_busy = 1'b0, fetch_fire = 1'b0;
   logic [PC_W-1:0] chk_pc = '0, oldest_pc = '0;
   logic flush, redirect_valid, fetch_en, degraded, exception;
   logic [PC_W-1:0] redirect_pc;
   logic [3:0] feat_off;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   degraded_recovery_ctrl uut (
      .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_ok(chk_ok),
      .chk_pc(chk_pc), .core_busy(core_busy), .oldest_pc(oldest_pc),
      .fetch_fire(fetch_fire), .flush(flush), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc), .fetch_en(fetch_en), .degraded(degraded),
      .feat_off(feat_off), .exception(exception)
   );

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      chk_valid = 0; chk_ok = 0; core_busy = 0; fetch_fire = 0;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
   endtask

   // one checker verdict lasting one cycle
   task automatic verdict(input logic ok, input logic [PC_W-1:0] pc);
      chk_valid = 1; chk_ok = ok; chk_pc = pc;
      tick();
      chk_valid = 0; chk_ok = 0;
   endtask

   task automatic fetch_one();
      fetch_fire = 1;
      tick();
      fetch_fire = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 fetch_en", fetch_en, 1);
      chk("R1 flush", flush, 0);
      chk("R1 redirect_valid", redirect_valid, 0);
      chk("R1 degraded", degraded, 0);
      chk("R1 exception", exception, 0);
      chk("R1 feat_off", feat_off, 0);
   endtask

   task automatic t_pass_normal();
      for (int i = 0; i < 4; i++) begin
         verdict(1, 32'h100 + i * 4);
         chk("R10 flush", flush, 0);
         chk("R10 degraded", degraded, 0);
         chk("R10 fetch_en", fetch_en, 1);
      end
   endtask

   task automatic t_fail_recover();
      verdict(0, 32'h0000_1000);
      chk("R2 flush", flush, 1);
      chk("R2 redirect_valid", redirect_valid, 1);
      chk("R2 redirect_pc", redirect_pc, 32'h1000);
      chk("R2 degraded", degraded, 1);
      chk("R4 feat_off degraded", feat_off, MASK);
      chk("R3 fetch_en before refetch", fetch_en, 1);
      tick();
      chk("R2 flush single", flush, 0);
      chk("R2 redirect single", redirect_valid, 0);
      // early verdicts before refetch are ignored
      verdict(0, 32'h0000_1004);
      chk("R8 still degraded", degraded, 1);
      chk("R8 no exception", exception, 0);
      chk("R8 fetch still open", fetch_en, 1);
      verdict(1, 32'h0000_1008);
      chk("R8 pass ignored", degraded, 1);
      fetch_one();
      chk("R3 fetch closed", fetch_en, 0);
      tick();
      tick();
      chk("R3 fetch stays closed", fetch_en, 0);
      chk("R3 still degraded", degraded, 1);
      verdict(1, 32'h0000_1000);
      chk("R5 degraded off", degraded, 0);
      chk("R5 fetch_en", fetch_en, 1);
      chk("R4 feat_off normal", feat_off, 0);
      chk("R5 no exception", exception, 0);
   endtask

   task automatic t_double_fail();
      verdict(0, 32'h0000_2000);
      chk("R2 entry", degraded, 1);
      tick();
      fetch_one();
      verdict(0, 32'h0000_2000);
      chk("R6 exception", exception, 1);
      chk("R6 fetch_en", fetch_en, 0);
      chk("R6 degraded", degraded, 0);
      // pound on it: nothing changes
      core_busy = 1;
      for (int i = 0; i < WD + 4; i++) begin
         chk_valid = i[0]; chk_ok = i[1]; fetch_fire = i[2]; chk_pc = 32'h3000 + i;
         tick();
         if (flush !== 0 || redirect_valid !== 0 || exception !== 1 || fetch_en !== 0)
            chk("R7 error hold", {flush, redirect_valid, exception, fetch_en}, 4'b0010);
      end
      idle_inputs();
      chk("R7 still error", exception, 1);
      do_reset();
      chk("R7 reset clears", exception, 0);
      chk("R7 fetch back", fetch_en, 1);
   endtask

   task automatic t_watchdog();
      oldest_pc = 32'h0000_4440;
      core_busy = 1;
      repeat (WD - 1) tick();
      chk("R9 no timeout at limit-1", degraded, 0);
      chk_valid = 1; chk_ok = 1; chk_pc = 32'h4440;
      tick();
      chk_valid = 0;
      repeat (WD - 1) tick();
      chk("R9 restart by verdict", degraded, 0);
      core_busy = 0;
      tick();
      core_busy = 1;
      repeat (WD - 1) tick();
      chk("R9 restart by idle", degraded, 0);
      tick();
      chk("R9 timeout degraded", degraded, 1);
      chk("R9 timeout flush", flush, 1);
      chk("R9 timeout redirect_pc", redirect_pc, 32'h4440);
      core_busy = 0;
      tick();
      fetch_one();
      verdict(1, 32'h4440);
      chk("R9 recovered", degraded, 0);
   endtask

   initial begin
      t_reset();
      t_pass_normal();
      t_fail_recover();
      t_double_fail();
      t_watchdog();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule